// File: doc/BRIEF.md
# Random Byte Generator with Task and Event Control

This peripheral produces a fresh random byte at a fixed interval for as long as it is running. Software or hardware controls it with one-shot *tasks*: a start task begins production and a stop task ends it. Each new byte raises a sticky *ready* flag and a one-cycle event pulse. A *link* bit can stop the generator automatically after the first byte. An interrupt line is the ready flag gated by an enable, and the enable can be written directly or through separate set and clear aliases.

The interval between bytes is counted in microsecond ticks, which a clock divider derives from the system clock. A *slow* bit chooses between a long and a short interval, and each is a parameter. A 16-bit Galois LFSR stands in for a physical noise source. It advances every clock, and its low byte is captured when the interval expires. All registers sit on a 32-bit bus with a 12-bit byte offset, a write strobe and registered read data.

Top module: `rand_byte_gen`

## Requirements
- R1: A write of exactly 32'h1 to offset 0x000, or a high `hw_start` in a cycle, starts the generator and restarts the interval from its full length, even when it is already running. A write of any other value to 0x000 has no effect.
- R2: A write of exactly 32'h1 to offset 0x004, or a high `hw_stop`, stops the generator and cancels the pending interval. A write of any other value has no effect. When a stop and a start arrive in the same cycle, the stop wins.
- R3: When the interval expires, the byte is loaded into the value register, the ready flag is set, and `evt_ready` is high for exactly one cycle. This happens CLK_PER_US × interval clock edges after the edge that accepted the start.
- R4: When bit 0 of offset 0x200 (link) is 1, the generator stops after delivering one byte. When it is 0, bytes keep arriving every interval.
- R5: `irq` is a registered output equal to enable AND ready flag, and it is updated at the same edge as either of them.
- R6: Bit 0 of a write to 0x300 sets the enable directly. A write to 0x304 with bit 0 = 1 sets the enable. A write to 0x308 with bit 0 = 1 clears the enable. Writes to these two aliases with bit 0 = 0 have no effect. Reads of all three offsets return the enable in bit 0.
- R7: Bit 0 of offset 0x504 (slow) selects LONG_US when it is 1 and SHORT_US when it is 0. The choice is sampled each time the interval is (re)loaded.
- R8: A read of 0x100 returns the ready flag in bit 0. A write of 0 to 0x100 clears the flag, and a nonzero write has no effect. A new byte in the same cycle as a clear wins over the clear.
- R9: After reset, the value, the running state, the ready flag, link, the enable and slow are all 0, and no interval is pending.
- R10: A read of any offset not listed here returns 0, and a write to such an offset changes no state. The value register at 0x508 is read-only, and its low 8 bits hold the byte.
- R11: The random source is a right-shifting Galois LFSR: next = (s >> 1) XOR (s[0] ? 16'hB400 : 0). It is loaded with the seed during reset and steps on every clock after that. The byte captured is the low 8 bits of the state before the expiring edge.
- R12: `rd_data` is registered. After an edge it shows the register that `addr` selected before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Byte offset of the register access |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data for the previous cycle's offset |
| hw_start | input | 1 | Hardware start task, level-sampled each cycle |
| hw_stop | input | 1 | Hardware stop task, level-sampled each cycle |
| evt_ready | output | 1 | One-cycle pulse per new byte |
| irq | output | 1 | Interrupt, enable AND ready flag |

## Verification
The assertions assume that `addr`, `wr_data` and the task inputs carry defined values in every cycle after reset. They also assume that the configured interval is at least two clock cycles, so that two event pulses can never fall in adjacent cycles. The bench drives every input at the falling edge and parks `addr` on a mapped or unmapped offset when idle. It uses a divider of 2 with intervals of 3 and 7 ticks, so every product stays well above that floor. The sweep covers all eight combinations of slow, link and enable. Separate directed steps cover the alias writes, ignored trigger values, simultaneous hardware tasks and unmapped offsets.

// File: rtl/rbg_pkg.sv
package rbg_pkg;

  localparam int RBG_ADDR_W = 12;
  localparam int RBG_DATA_W = 32;

  localparam logic [RBG_ADDR_W-1:0] OFS_GO      = 12'h000;
  localparam logic [RBG_ADDR_W-1:0] OFS_HALT    = 12'h004;
  localparam logic [RBG_ADDR_W-1:0] OFS_READY   = 12'h100;
  localparam logic [RBG_ADDR_W-1:0] OFS_LINK    = 12'h200;
  localparam logic [RBG_ADDR_W-1:0] OFS_IEN     = 12'h300;
  localparam logic [RBG_ADDR_W-1:0] OFS_IEN_SET = 12'h304;
  localparam logic [RBG_ADDR_W-1:0] OFS_IEN_CLR = 12'h308;
  localparam logic [RBG_ADDR_W-1:0] OFS_SLOW    = 12'h504;
  localparam logic [RBG_ADDR_W-1:0] OFS_DATA    = 12'h508;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_GO,
    SEL_HALT,
    SEL_READY,
    SEL_LINK,
    SEL_IEN,
    SEL_IEN_SET,
    SEL_IEN_CLR,
    SEL_SLOW,
    SEL_DATA
  } rbg_sel_e;

  function automatic rbg_sel_e rbg_decode(input logic [RBG_ADDR_W-1:0] a);
    rbg_sel_e s;
    case (a)
      OFS_GO:      s = SEL_GO;
      OFS_HALT:    s = SEL_HALT;
      OFS_READY:   s = SEL_READY;
      OFS_LINK:    s = SEL_LINK;
      OFS_IEN:     s = SEL_IEN;
      OFS_IEN_SET: s = SEL_IEN_SET;
      OFS_IEN_CLR: s = SEL_IEN_CLR;
      OFS_SLOW:    s = SEL_SLOW;
      OFS_DATA:    s = SEL_DATA;
      default:     s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/rbg_lfsr.sv
module rbg_lfsr #(
  parameter int                W     = 16,
  parameter int                OUT_W = 8,
  parameter logic [W-1:0]      TAPS  = 16'hB400,
  parameter logic [W-1:0]      SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [OUT_W-1:0] rnd
);

  logic [W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEED;
    end else begin
      state_q <= (state_q >> 1) ^ (state_q[0] ? TAPS : '0);
    end
  end

  assign rnd = state_q[OUT_W-1:0];

  // R11: a maximal Galois register seeded nonzero never reaches zero
  p_lfsr_live_r11: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);

endmodule

// File: rtl/rbg_interval.sv
module rbg_interval #(
  parameter int CLK_PER_US = 125,
  parameter int SHORT_US   = 167,
  parameter int LONG_US    = 660
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic halt,
  input  logic stop_on_ready,
  input  logic long_sel,
  output logic expire,
  output logic running
);

  localparam int MAX_US = (LONG_US > SHORT_US) ? LONG_US : SHORT_US;
  localparam int REM_W  = $clog2(MAX_US + 1);

  logic             run_q;
  logic [REM_W-1:0] rem_q;
  logic [REM_W-1:0] reload;
  logic             tick;

  assign reload = long_sel ? REM_W'(LONG_US) : REM_W'(SHORT_US);

  generate
    if (CLK_PER_US == 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DIV_W = $clog2(CLK_PER_US);
      logic [DIV_W-1:0] div_q;
      assign tick = (div_q == DIV_W'(CLK_PER_US - 1));
      always_ff @(posedge clk) begin
        if (rst || halt || arm) begin
          div_q <= '0;
        end else if (run_q) begin
          div_q <= tick ? '0 : div_q + DIV_W'(1);
        end
      end
    end
  endgenerate

  assign expire  = run_q & tick & (rem_q == REM_W'(1)) & ~halt;
  assign running = run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      rem_q <= '0;
    end else begin
      if (halt)
        run_q <= 1'b0;
      else if (arm)
        run_q <= 1'b1;
      else if (expire && stop_on_ready)
        run_q <= 1'b0;

      if (halt)
        rem_q <= '0;
      else if (arm)
        rem_q <= reload;
      else if (run_q && tick)
        rem_q <= (rem_q == REM_W'(1)) ? reload : rem_q - REM_W'(1);
    end
  end

  // R2: a stop request always leaves the generator idle
  p_halt_idles_r2: assert property (@(posedge clk) disable iff (rst)
    halt |=> !run_q);

  // R1: a start without a stop leaves it running
  p_arm_runs_r1: assert property (@(posedge clk) disable iff (rst)
    (arm && !halt) |=> run_q);

  // R7: a live countdown stays within the configured range
  p_rem_range_r7: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (rem_q != '0) && (rem_q <= REM_W'(MAX_US)));

endmodule

// File: rtl/rbg_regs.sv
module rbg_regs
  import rbg_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [RBG_ADDR_W-1:0] addr,
  input  logic                  wr_en,
  input  logic [RBG_DATA_W-1:0] wr_data,
  input  logic                  hw_start,
  input  logic                  hw_stop,
  input  logic                  expire,
  input  logic [BYTE_W-1:0]     rnd,
  output logic                  start_req,
  output logic                  stop_req,
  output logic                  link,
  output logic                  slow,
  output logic [RBG_DATA_W-1:0] rd_data,
  output logic                  evt_ready,
  output logic                  irq
);

  rbg_sel_e              sel;
  logic                  is_one;
  logic                  flag_q, flag_n;
  logic                  ien_q, ien_n;
  logic                  link_q, slow_q;
  logic [BYTE_W-1:0]     value_q;
  logic                  evt_q, irq_q;
  logic [RBG_DATA_W-1:0] rd_q, rd_n;

  assign sel    = rbg_decode(addr);
  assign is_one = (wr_data == RBG_DATA_W'(1));

  assign start_req = hw_start | (wr_en & (sel == SEL_GO) & is_one);
  assign stop_req  = hw_stop  | (wr_en & (sel == SEL_HALT) & is_one);

  always_comb begin
    flag_n = flag_q;
    if (expire)
      flag_n = 1'b1;
    else if (wr_en && sel == SEL_READY && wr_data == '0)
      flag_n = 1'b0;

    ien_n = ien_q;
    if (wr_en) begin
      case (sel)
        SEL_IEN:     ien_n = wr_data[0];
        SEL_IEN_SET: if (wr_data[0]) ien_n = 1'b1;
        SEL_IEN_CLR: if (wr_data[0]) ien_n = 1'b0;
        default:     ien_n = ien_q;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_READY:   rd_n = RBG_DATA_W'(flag_q);
      SEL_LINK:    rd_n = RBG_DATA_W'(link_q);
      SEL_IEN,
      SEL_IEN_SET,
      SEL_IEN_CLR: rd_n = RBG_DATA_W'(ien_q);
      SEL_SLOW:    rd_n = RBG_DATA_W'(slow_q);
      SEL_DATA:    rd_n = RBG_DATA_W'(value_q);
      default:     rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      ien_q   <= 1'b0;
      link_q  <= 1'b0;
      slow_q  <= 1'b0;
      value_q <= '0;
      evt_q   <= 1'b0;
      irq_q   <= 1'b0;
      rd_q    <= '0;
    end else begin
      flag_q <= flag_n;
      ien_q  <= ien_n;
      if (wr_en && sel == SEL_LINK) link_q <= wr_data[0];
      if (wr_en && sel == SEL_SLOW) slow_q <= wr_data[0];
      if (expire) value_q <= rnd;
      evt_q  <= expire;
      irq_q  <= ien_n & flag_n;
      rd_q   <= rd_n;
    end
  end

  assign link      = link_q;
  assign slow      = slow_q;
  assign rd_data   = rd_q;
  assign evt_ready = evt_q;
  assign irq       = irq_q;

  // R3: every event pulse comes with the ready flag raised
  p_evt_flag_r3: assert property (@(posedge clk) disable iff (rst)
    evt_q |-> flag_q);

  // R3: the value register only moves on an expiry
  p_value_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !expire |=> $stable(value_q));

  // R5: the interrupt never rises without both enable and flag
  p_irq_mask_r5: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (ien_q && flag_q));

  // R10: an unmapped offset reads back as zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_NONE) |=> (rd_q == '0));

endmodule

// File: rtl/rand_byte_gen.sv
module rand_byte_gen
  import rbg_pkg::*;
#(
  parameter int                  CLK_PER_US = 125,
  parameter int                  SHORT_US   = 167,
  parameter int                  LONG_US    = 660,
  parameter int                  LFSR_W     = 16,
  parameter logic [LFSR_W-1:0]   LFSR_TAPS  = 16'hB400,
  parameter logic [LFSR_W-1:0]   LFSR_SEED  = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [11:0] addr,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        hw_start,
  input  logic        hw_stop,
  output logic        evt_ready,
  output logic        irq
);

  localparam int BYTE_W = 8;

  logic [BYTE_W-1:0] rnd;
  logic              start_req, stop_req, link, slow;
  logic              expire, running;

  rbg_lfsr #(
    .W(LFSR_W), .OUT_W(BYTE_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)
  ) u_lfsr (
    .clk(clk), .rst(rst), .rnd(rnd)
  );

  rbg_interval #(
    .CLK_PER_US(CLK_PER_US), .SHORT_US(SHORT_US), .LONG_US(LONG_US)
  ) u_interval (
    .clk(clk), .rst(rst), .arm(start_req), .halt(stop_req),
    .stop_on_ready(link), .long_sel(slow),
    .expire(expire), .running(running)
  );

  rbg_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .hw_start(hw_start), .hw_stop(hw_stop), .expire(expire), .rnd(rnd),
    .start_req(start_req), .stop_req(stop_req), .link(link), .slow(slow),
    .rd_data(rd_data), .evt_ready(evt_ready), .irq(irq)
  );

  // R4: with link set, an expiry ends the run unless a start coincides
  p_link_stops_r4: assert property (@(posedge clk) disable iff (rst)
    (expire && link && !start_req) |=> !running);

endmodule

// File: tb/sim_rand_byte_gen.sv
`timescale 1ns/1ps
module sim_rand_byte_gen;

  localparam int D  = 2;
  localparam int NS = 3;
  localparam int NL = 7;
  localparam logic [15:0] SEED = 16'hACE1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] addr = 12'h010;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        hw_start = 1'b0, hw_stop = 1'b0;
  logic        evt_ready, irq;

  int checks = 0, fails = 0;
  logic [15:0] m_cur, m_prev;

  always #4 clk = ~clk;

  rand_byte_gen #(
    .CLK_PER_US(D), .SHORT_US(NS), .LONG_US(NL), .LFSR_SEED(SEED)
  ) u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .hw_start(hw_start), .hw_stop(hw_stop),
    .evt_ready(evt_ready), .irq(irq)
  );

  // R11 reference sequence, stepped from the written polynomial
  always @(posedge clk) begin
    if (rst) begin
      m_cur  <= SEED;
      m_prev <= SEED;
    end else begin
      m_prev <= m_cur;
      m_cur  <= (m_cur >> 1) ^ (m_cur[0] ? 16'hB400 : 16'h0);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = 12'h010;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    @(negedge clk);
    d = rd_data;
    addr = 12'h010;
  endtask

  task automatic wait_evt(input int lim, output int k);
    k = 0;
    while (!evt_ready && k < lim) begin
      @(negedge clk);
      k++;
    end
  endtask

  initial begin
    #(200000 * 8);
    fails++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int k;
    logic [7:0] exp_b;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9 reset state
    chk(!irq && !evt_ready, "R9 outputs", {irq, evt_ready}, 0);
    rd(12'h100, r); chk(r == 0, "R9 flag", r, 0);
    rd(12'h200, r); chk(r == 0, "R9 link", r, 0);
    rd(12'h300, r); chk(r == 0, "R9 enable", r, 0);
    rd(12'h504, r); chk(r == 0, "R9 slow", r, 0);
    rd(12'h508, r); chk(r == 0, "R9 value", r, 0);

    // Sweep: slow x link x enable (R3 R4 R5 R7 R8 R11)
    for (int cfg = 0; cfg < 2; cfg++)
      for (int lnk = 0; lnk < 2; lnk++)
        for (int ie = 0; ie < 2; ie++) begin
          int nd;
          nd = (cfg ? NL : NS) * D;
          wr(12'h004, 32'h1);
          wr(12'h100, 32'h0);
          wr(12'h504, cfg);
          wr(12'h200, lnk);
          wr(12'h300, ie);
          wr(12'h000, 32'h1);
          wait_evt(4 * nd, k);
          exp_b = m_prev[7:0];
          chk(k == nd, "R3 R7 interval", k, nd);
          chk(irq == ie[0], "R5 irq", irq, ie);
          rd(12'h508, r);
          chk(r == {24'h0, exp_b}, "R11 byte", r, exp_b);
          rd(12'h100, r);
          chk(r == 1, "R8 flag read", r, 1);
          if (lnk) begin
            k = 2;
            while (k < 3 * nd && !evt_ready) begin @(negedge clk); k++; end
            chk(!evt_ready, "R4 link stops", evt_ready, 0);
          end else begin
            k = 2;
            while (k < 3 * nd && !evt_ready) begin @(negedge clk); k++; end
            chk(k == nd, "R4 continuous", k, nd);
          end
        end
    wr(12'h004, 32'h1);

    // R12 read latency: data follows the previous offset
    wr(12'h200, 32'h1);
    rd(12'h200, r);
    addr = 12'h010; #1;
    chk(rd_data == 1, "R12 latency", rd_data, 1);
    @(negedge clk);
    chk(rd_data == 0, "R12 follow", rd_data, 0);
    wr(12'h200, 32'h0);
    wr(12'h504, 32'h0);

    // R1 non-trigger value ignored
    wr(12'h000, 32'h2);
    wait_evt(3 * NL * D, k);
    chk(!evt_ready, "R1 value 2 ignored", evt_ready, 0);

    // R2 stop with other value ignored, then real stop cancels
    wr(12'h000, 32'h1);
    wr(12'h004, 32'h3);
    wait_evt(4 * NS * D, k);
    chk(k == NS * D - 1, "R2 value 3 ignored", k, NS * D - 1);
    wr(12'h000, 32'h1);
    wr(12'h004, 32'h1);
    wait_evt(3 * NL * D, k);
    chk(!evt_ready, "R2 stop cancels", evt_ready, 0);

    // R1 restart while running restarts the full interval
    wr(12'h000, 32'h1);
    repeat (3) @(negedge clk);
    wr(12'h000, 32'h1);
    wait_evt(4 * NS * D, k);
    chk(k == NS * D, "R1 restart", k, NS * D);
    wr(12'h004, 32'h1);

    // R1 hardware start, R2 hardware start+stop together
    hw_start = 1'b1; @(negedge clk); hw_start = 1'b0;
    wait_evt(4 * NS * D, k);
    chk(k == NS * D, "R1 hw start", k, NS * D);
    hw_stop = 1'b1; @(negedge clk); hw_stop = 1'b0;
    hw_start = 1'b1; hw_stop = 1'b1; @(negedge clk);
    hw_start = 1'b0; hw_stop = 1'b0;
    wait_evt(3 * NL * D, k);
    chk(!evt_ready, "R2 stop wins", evt_ready, 0);

    // R8 nonzero write keeps flag; R6 aliases drive irq
    wr(12'h100, 32'h5);
    rd(12'h100, r); chk(r == 1, "R8 nonzero ignored", r, 1);
    wr(12'h300, 32'h0);
    wr(12'h304, 32'h2);
    rd(12'h300, r); chk(r == 0, "R6 set bit0 clear", r, 0);
    wr(12'h304, 32'h1);
    chk(irq == 1, "R6 R5 set alias irq", irq, 1);
    rd(12'h308, r); chk(r == 1, "R6 clr alias read", r, 1);
    wr(12'h308, 32'h2);
    chk(irq == 1, "R6 clr bit0 clear", irq, 1);
    wr(12'h308, 32'h1);
    chk(irq == 0, "R6 clr alias", irq, 0);
    wr(12'h304, 32'h1);
    wr(12'h100, 32'h0);
    chk(irq == 0, "R8 R5 clear drops irq", irq, 0);
    rd(12'h100, r); chk(r == 0, "R8 cleared", r, 0);

    // R10 unmapped and read-only
    rd(12'h508, r);
    exp_b = r[7:0];
    wr(12'h508, 32'hFF ^ {24'h0, exp_b});
    rd(12'h508, r); chk(r == {24'h0, exp_b}, "R10 value read-only", r, exp_b);
    wr(12'h204, 32'h1);
    rd(12'h200, r); chk(r == 0, "R10 unmapped write", r, 0);
    wr(12'h010, 32'h1);
    wait_evt(3 * NL * D, k);
    chk(!evt_ready, "R10 unmapped no start", evt_ready, 0);
    rd(12'h7FC, r); chk(r == 0, "R10 unmapped read", r, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule